// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a two-wire serial slave that loads a small bank of 9-bit control registers. A bus master selects the slave by its 7-bit device address, which carries one address bit taken from a strap pin. The master then sends two bytes that together form a 16-bit control word: a 7-bit register index and 9 data bits. The slave does not run on the serial clock. A faster system clock samples the clock and data lines, and the block drives the data line only through an open-drain enable that pulls the line low.

The volume registers come in left/right pairs. A write to either register of a pair can load the other register as well, so one bus transaction moves both channels together. A write to a dedicated index returns every register to its power-on value. To read a register, the master writes the register index, issues a repeated start with the read bit set, and receives the low eight data bits first and then a byte that holds data bit 8. Register contents are plain output pins that the rest of the chip decodes. Data only enters or leaves through the serial bus, so there is no valid/ready stream at the edge of this block and nothing applies back-pressure.

Top module: `ctrl_reg_slave`

## Requirements
- R1: The slave acknowledges the device address 0x1A when `addr_sel` is low and 0x1B when it is high. It does not acknowledge any other device address, and a transaction sent to another address changes no register.
- R2: In a write, the first byte after the device address holds the register index in bits 7..1 and data bit 8 in bit 0. The second byte holds data bits 7..0. When the write completes, the 9-bit register at that index holds the written value.
- R3: The slave acknowledges its device address and every data byte it receives by holding the data line low through the ninth clock of that byte.
- R4: A read starts with a write of the register index, followed by a repeated start and the device address with the read bit set. The slave then returns data bits 7..0, MSB first. After the master acknowledges, it returns a byte of seven zeros followed by data bit 8. A not-acknowledge from the master ends the read and releases the line.
- R5: A write to index 0 with data bit 8 set also loads index 1 with the same 9-bit value. A write to index 1 with bit 8 set also loads index 0. With bit 8 clear, only the addressed register changes.
- R6: Indices 2 and 3 are linked in the same way as indices 0 and 1.
- R7: After reset, the registers hold index 0 = 0x097, index 1 = 0x097, index 2 = 0x079, index 3 = 0x079, index 4 = 0x00A, index 5 = 0x008, index 6 = 0x09F, and zero at every other index.
- R8: A completed write to index 0x0F, whatever its data, returns every register to its R7 value.
- R9: A write to an index that has no register (0x0A to 0x0E, or 0x10 and above) is acknowledged and changes nothing. A read from such an index returns zero.
- R10: A register changes only after its second data byte has been fully received and acknowledged. A stop that comes earlier leaves every register unchanged.
- R11: The slave changes its drive of the data line only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low reset; loads the power-on values |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level, as seen on the wire |
| sda_oe | output | 1 | When 1, the slave pulls the data line low |
| addr_sel | input | 1 | Strap pin that sets the least significant bit of the device address |
| regs_o | output | REG_COUNT*9 | All registers; register k sits at bits k*9+8 down to k*9 |

## Verification
The bench uses the default parameters: ten implemented registers, a two-stage synchronizer, a base device address of 0x1A, and linked pairs below index 4. It drives the serial clock with a quarter period of eight system clocks, which leaves enough time for the synchronizer and edge detector to act before each line transition. Both levels of the strap pin are used. This lets the bench test the address match and reject against a single pin. With ten registers and the soft-reset index at 0x0F, the unimplemented gap from 0x0A to 0x0E can also be tested.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;
  localparam int DW = 9;
  localparam int AW = 7;
  localparam logic [AW-1:0] SRST_INDEX = 7'h0F;

  typedef enum logic [2:0] {
    LS_IDLE, LS_DEV, LS_WR, LS_ACK, LS_RD, LS_RACK, LS_SKIP
  } link_state_t;

  function automatic logic [DW-1:0] power_on_value(input int idx);
    case (idx)
      0, 1:    return 9'h097;
      2, 3:    return 9'h079;
      4:       return 9'h00A;
      5:       return 9'h008;
      6:       return 9'h09F;
      default: return 9'h000;
    endcase
  endfunction

  function automatic logic [7:0] readback_byte(input logic [DW-1:0] v,
                                               input logic [1:0] idx);
    case (idx)
      2'd0:    return v[7:0];
      2'd1:    return {7'b0, v[8]};
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_i};
      sda_sh <= {sda_sh[LAST-1:0], sda_i};
      scl_q  <= scl_sh[LAST];
      sda_q  <= sda_sh[LAST];
    end
  end

  assign scl_s     = scl_sh[LAST];
  assign sda_s     = sda_sh[LAST];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/link_engine.sv
module link_engine
  import ctrl_reg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [AW-1:0] dev_addr,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          sda_oe
);
  link_state_t state;
  logic [7:0] shreg;
  logic [3:0] bit_cnt;
  logic [1:0] wr_phase;
  logic [1:0] rd_idx;
  logic       is_read, commit, nack, hi_bit;
  logic [7:0] lo_byte, tx_byte, tx_next;
  logic [1:0] rd_idx_next;

  assign rd_idx_next = (rd_idx == 2'd3) ? rd_idx : rd_idx + 2'd1;
  assign tx_byte     = readback_byte(rd_data, rd_idx);
  assign tx_next     = readback_byte(rd_data, rd_idx_next);
  assign wr_data     = {hi_bit, lo_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LS_IDLE;
      shreg    <= '0;
      bit_cnt  <= '0;
      wr_phase <= '0;
      rd_idx   <= '0;
      is_read  <= 1'b0;
      commit   <= 1'b0;
      nack     <= 1'b0;
      hi_bit   <= 1'b0;
      lo_byte  <= '0;
      ptr      <= '0;
      wr_en    <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= LS_DEV;
        bit_cnt  <= '0;
        wr_phase <= '0;
        commit   <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        state  <= LS_IDLE;
        commit <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          LS_DEV, LS_WR: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == LS_DEV) begin
                if (shreg[7:1] == dev_addr) begin
                  sda_oe  <= 1'b1;
                  state   <= LS_ACK;
                  is_read <= shreg[0];
                  rd_idx  <= '0;
                end else begin
                  state <= LS_SKIP;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= LS_ACK;
                if (wr_phase == 2'd0) begin
                  ptr      <= shreg[7:1];
                  hi_bit   <= shreg[0];
                  wr_phase <= 2'd1;
                end else if (wr_phase == 2'd1) begin
                  lo_byte  <= shreg;
                  commit   <= 1'b1;
                  wr_phase <= 2'd2;
                end
              end
            end
          end
          LS_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (commit) begin
                wr_en  <= 1'b1;
                commit <= 1'b0;
              end
              if (is_read) begin
                state  <= LS_RD;
                sda_oe <= ~tx_byte[7];
              end else begin
                state  <= LS_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          LS_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= LS_RACK;
              end else begin
                sda_oe <= ~tx_byte[3'(4'd7 - bit_cnt)];
              end
            end
          end
          LS_RACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                state <= LS_SKIP;
              end else begin
                state   <= LS_RD;
                bit_cnt <= '0;
                rd_idx  <= rd_idx_next;
                sda_oe  <= ~tx_next[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ACK_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_ACK && scl_rise) |-> !sda_s); // R3
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R11
  AST_COMMIT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(state == LS_ACK)); // R10
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import ctrl_reg_pkg::*;
#(
  parameter int REG_COUNT  = 10,
  parameter int LINK_LIMIT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [DW-1:0]           rd_data,
  output logic [REG_COUNT*DW-1:0] regs_o
);
  localparam logic [AW-1:0] TOP_INDEX = AW'(REG_COUNT);

  logic [DW-1:0] regs [REG_COUNT];
  logic [REG_COUNT*DW-1:0] dflt_vec;
  logic srst;

  assign srst = wr_en && (wr_addr == SRST_INDEX);

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    localparam logic [AW-1:0] SELF   = AW'(g);
    localparam logic [AW-1:0] MATE   = AW'(g ^ 1);
    localparam bit            LINKED = (g < LINK_LIMIT);
    logic hit;

    assign hit = wr_en && ((wr_addr == SELF) ||
                 (LINKED && (wr_addr == MATE) && wr_data[DW-1]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs[g] <= power_on_value(g);
      else if (srst)  regs[g] <= power_on_value(g);
      else if (hit)   regs[g] <= wr_data;
    end

    assign regs_o[g*DW +: DW]   = regs[g];
    assign dflt_vec[g*DW +: DW] = power_on_value(g);

    if (LINKED) begin : g_link_chk
      AST_LINK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SELF && wr_data[DW-1]) |=> regs[g] == regs[g ^ 1]); // R5 R6
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < REG_COUNT; k++)
      if (rd_addr == AW'(k)) rd_data = regs[k];
  end

  AST_UNIMPL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= TOP_INDEX && !srst) |=> $stable(regs_o)); // R9
  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> regs_o == dflt_vec); // R8
endmodule

// File: rtl/ctrl_reg_slave.sv
module ctrl_reg_slave
  import ctrl_reg_pkg::*;
#(
  parameter int            REG_COUNT   = 10,
  parameter int            LINK_LIMIT  = 4,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] DEV_BASE    = 7'h1A
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  input  logic                    addr_sel,
  output logic [REG_COUNT*DW-1:0] regs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [AW-1:0] ptr, dev_addr;
  logic [DW-1:0] wr_data, rd_data;

  assign dev_addr = {DEV_BASE[AW-1:1], addr_sel};

  bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  link_engine u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .dev_addr(dev_addr), .rd_data(rd_data), .ptr(ptr),
    .wr_en(wr_en), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  reg_bank #(.REG_COUNT(REG_COUNT), .LINK_LIMIT(LINK_LIMIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data), .regs_o(regs_o)
  );
endmodule

// File: tb/ctrl_reg_slave_test.sv
module ctrl_reg_slave_test;
  localparam int NREG = 10;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, addr_sel = 1'b0;
  logic sda_oe, bus_sda;
  logic [NREG*9-1:0] regs_o;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] exp_q[$];
  logic [8:0] got_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;
  assign bus_sda = m_sda & ~sda_oe;

  ctrl_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
    .sda_oe(sda_oe), .addr_sel(addr_sel), .regs_o(regs_o)
  );

  function automatic logic [8:0] pov(input int i);
    case (i)
      0, 1: return 9'h097;
      2, 3: return 9'h079;
      4: return 9'h00A;
      5: return 9'h008;
      6: return 9'h09F;
      default: return 9'h000;
    endcase
  endfunction

  function automatic logic [NREG*9-1:0] pov_all();
    logic [NREG*9-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*9 +: 9] = pov(i);
    return v;
  endfunction

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic hold(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; hold();
    m_sda = 1'b0; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b0; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b1; hold();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; hold();
      m_scl = 1'b1; hold();
      m_scl = 1'b0; hold();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; hold();
    m_scl = 1'b1; repeat (Q/2) @(negedge clk);
    ack = ~bus_sda; repeat (Q/2) @(negedge clk);
    m_scl = 1'b0; hold();
  endtask

  task automatic recv_byte(input logic give_nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold();
      m_scl = 1'b1; repeat (Q/2) @(negedge clk);
      b[i] = bus_sda; repeat (Q/2) @(negedge clk);
      m_scl = 1'b0;
    end
    hold();
    m_sda = give_nack; hold();
    m_scl = 1'b1; hold();
    m_scl = 1'b0; hold();
  endtask

  // full write transaction; returns the three acknowledge bits
  task automatic reg_write(input logic [6:0] dev, input logic [6:0] idx,
                           input logic [8:0] val, output logic [2:0] acks);
    logic a;
    bus_start();
    send_byte({dev, 1'b0}, a); acks[2] = a;
    send_byte({idx, val[8]}, a); acks[1] = a;
    send_byte(val[7:0], a); acks[0] = a;
    bus_stop();
  endtask

  // driver: pushes the expected value, then reads back the register
  task automatic reg_read(input string tag, input logic [6:0] dev,
                          input logic [6:0] idx, input logic [8:0] exp);
    logic a;
    logic [7:0] lo, hi;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_start();
    send_byte({dev, 1'b0}, a);
    check({tag, " R3 ack dev"}, a, 1'b1);
    send_byte({idx, 1'b0}, a);
    check({tag, " R3 ack index"}, a, 1'b1);
    bus_rstart();
    send_byte({dev, 1'b1}, a);
    check({tag, " R3 ack read addr"}, a, 1'b1);
    recv_byte(1'b0, lo);
    recv_byte(1'b1, hi);
    bus_stop();
    check({tag, " R4 upper bits zero"}, hi[7:1], 7'd0);
    got_q.push_back({hi[0], lo});
  endtask

  // monitor: compares read-back values as they arrive
  initial begin
    forever begin
      @(negedge clk);
      if (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [8:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, g, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [NREG*9-1:0] snap;
    logic a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check("R7 reset defaults", regs_o, pov_all());
    check("R11 idle release", sda_oe, 1'b0);

    // R1 R2: address 0x1A with pin low
    reg_write(7'h1A, 7'd4, 9'h155, acks);
    check("R1 R3 acks on 0x1A", acks, 3'b111);
    check("R2 reg4 written", regs_o[4*9 +: 9], 9'h155);

    // R1: wrong address ignored
    snap = regs_o;
    reg_write(7'h1B, 7'd4, 9'h0F0, acks);
    check("R1 no ack on 0x1B with pin low", acks[2], 1'b0);
    check("R1 foreign write ignored", regs_o, snap);

    // R1: pin high moves the address
    addr_sel = 1'b1;
    reg_write(7'h1B, 7'd5, 9'h0AA, acks);
    check("R1 acks on 0x1B", acks, 3'b111);
    check("R2 reg5 written", regs_o[5*9 +: 9], 9'h0AA);
    reg_read("R4 read reg4", 7'h1B, 7'd4, 9'h155);
    reg_read("R4 read reg5", 7'h1B, 7'd5, 9'h0AA);

    // R5: input volume pair
    reg_write(7'h1B, 7'd0, 9'h12C, acks);
    check("R5 left loads left", regs_o[0 +: 9], 9'h12C);
    check("R5 left loads right", regs_o[9 +: 9], 9'h12C);
    reg_write(7'h1B, 7'd1, 9'h033, acks);
    check("R5 unlinked right", regs_o[9 +: 9], 9'h033);
    check("R5 left kept", regs_o[0 +: 9], 9'h12C);
    reg_write(7'h1B, 7'd1, 9'h145, acks);
    check("R5 right loads left", regs_o[0 +: 9], 9'h145);

    // R6: headphone pair
    reg_write(7'h1B, 7'd3, 9'h17F, acks);
    check("R6 right loads left", regs_o[2*9 +: 9], 9'h17F);
    check("R6 right loaded", regs_o[3*9 +: 9], 9'h17F);
    reg_write(7'h1B, 7'd2, 9'h050, acks);
    check("R6 unlinked left", regs_o[2*9 +: 9], 9'h050);
    check("R6 right kept", regs_o[3*9 +: 9], 9'h17F);
    reg_read("R4 R5 read bit8", 7'h1B, 7'd0, 9'h145);

    // R9: unimplemented index
    snap = regs_o;
    reg_write(7'h1B, 7'h0C, 9'h1FF, acks);
    check("R9 acks unimplemented", acks, 3'b111);
    check("R9 nothing changed", regs_o, snap);
    reg_write(7'h1B, 7'h40, 9'h1FF, acks);
    check("R9 high index ignored", regs_o, snap);
    reg_read("R9 read unimplemented", 7'h1B, 7'h0C, 9'h000);

    // R10: stop after first data byte, and in the middle of the second
    bus_start();
    send_byte({7'h1B, 1'b0}, a);
    send_byte({7'd5, 1'b1}, a);
    bus_stop();
    check("R10 stop after first byte", regs_o, snap);
    bus_start();
    send_byte({7'h1B, 1'b0}, a);
    send_byte({7'd5, 1'b1}, a);
    send_bits(8'h00, 4);
    bus_stop();
    check("R10 stop inside second byte", regs_o, snap);

    // R8: soft reset
    reg_write(7'h1B, 7'h0F, 9'h000, acks);
    check("R8 soft reset ack", acks, 3'b111);
    check("R8 defaults restored", regs_o, pov_all());
    reg_read("R7 R4 read reg6 default", 7'h1B, 7'd6, 9'h09F);

    repeat (20) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule